// File: doc/BRIEF.md
# Banked Converter Context Register File

This block is the register file of a data converter that can run several configurations in turn. It keeps four copies ("contexts") of the per-conversion settings, status and result bytes. One global control byte, one conversion-clock byte and one trigger-source byte are shared by all four copies. Software reaches everything through a byte-wide bus: a 6-bit address, a write strobe, write data and combinational read data. A context-select register chooses which copy the bus opens. The main control byte is global except for its continuous-run bit, which is stored once per context.

The context-select register has two modes. In software mode, software writes the context number and the bus follows it. In display mode, the context field is read-only and shows the context the external sequencer is scanning. After a stop request it shows the context the sequencer stopped on.

A three-state machine tracks the sequencer, with the states ST_IDLE, ST_SCAN and ST_HALT.
- ST_IDLE → ST_SCAN (EN_ON) when the sequencing-enable bit is 1.
- ST_IDLE → ST_HALT (EN_ON_STOP) when enable is 1 and `seq_stop` is 1 in the same cycle.
- ST_SCAN → ST_HALT (STOP) on `seq_stop`, which also latches `seq_ctx`.
- ST_SCAN → ST_IDLE and ST_HALT → ST_IDLE (EN_OFF) when enable is 0.
- Every state holds otherwise. ST_HALT stays put on further stops.

Top module: `ctxrf_top`

## Requirements
- R1: Exactly four banks store the per-context bytes at addresses 0x04 to 0x21. In software mode the bus reaches the bank numbered by the context field, bits 1:0 of the select byte at 0x01.
- R2: The clock byte (0x02) and the trigger byte (0x03) are single global registers, 8 bits each. A write under any selected context is read back under every context.
- R3: The main control byte (0x00) is global in bits 7 and 5:0. Bit 6 (continuous run) is stored per context and follows the accessed bank.
- R4: In the select byte, bit 7 is display-select and bits 1:0 are the context field; all other bits read 0. With bit 7 at 0, the field reads back the last value software wrote.
- R5: While display-select is 1, writes to the field are ignored, and the field shows the sequencer context `seq_ctx`, or the latched context after a stop. Bit 7 itself stays writable.
- R6: In display mode, the field reads 0 whenever the sequencing-enable bit (bit 5 of 0x00) is 0.
- R7: With enable at 1, a cycle with `seq_stop` high latches `seq_ctx`. The displayed field then holds that value, whatever `seq_ctx` does, until enable is cleared.
- R8: In display mode, banked accesses and the bit-6 access go to the displayed context.
- R9: Unimplemented bits read 0 and ignore writes, with these masks:
  - 0x08: 0x13
  - 0x09: 0x3F
  - 0x0B and 0x0D (13-bit counter high bytes): 0x1F
  - 0x0E: 0x1F
  - 0x19 (top byte of the 18-bit accumulator): 0x03
- R10: Addresses 0x22 to 0x3F read 0, and writes to them change nothing.
- R11: After reset, every bank, every global register and the select byte read 0, which means software mode with context 0.
- R12: A write takes effect at the clock edge where `bus_we` is sampled high. Read data is combinational from the registered state and the sequencer inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| seq_ctx | input | 2 | Context the sequencer is scanning now |
| seq_stop | input | 1 | Sequencer stopped on a threshold event |

## Verification
Read data has no latency, so it is due in the same cycle as the address and the current `seq_ctx`. A write, a select change or a stop takes effect one clock edge after it is presented. The bench drives every input just after a falling edge and compares `bus_rdata` one time unit later. It compares against a model that it updates once per cycle, after the comparison, so each expected value reflects exactly the edges that have already occurred. Directed cases cover the following:
- a stop followed by a changing `seq_ctx`;
- a write to the field while display mode is on;
- display mode with enable off.

Constrained-random traffic mixes these with ordinary bank traffic.

// File: rtl/ctxrf_pkg.sv
package ctxrf_pkg;

    localparam int CTX_W      = 2;
    localparam int NUM_CTX    = 1 << CTX_W;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 8;

    localparam logic [ADDR_W-1:0] A_MAIN    = 6'h00;
    localparam logic [ADDR_W-1:0] A_SEL     = 6'h01;
    localparam logic [ADDR_W-1:0] A_CLKSEL  = 6'h02;
    localparam logic [ADDR_W-1:0] A_TRIG    = 6'h03;
    localparam logic [ADDR_W-1:0] A_BANK_LO = 6'h04;
    localparam logic [ADDR_W-1:0] A_BANK_HI = 6'h21;
    localparam int BANK_BYTES = int'(A_BANK_HI) - int'(A_BANK_LO) + 1;

    localparam int BIT_CONT  = 6;
    localparam int BIT_SEQEN = 5;
    localparam int BIT_DISP  = 7;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;

    // Implemented bits of one banked byte; zero outside the banked window.
    function automatic logic [DATA_W-1:0] bank_mask(input logic [ADDR_W-1:0] a);
        logic [DATA_W-1:0] m;
        if (a < A_BANK_LO || a > A_BANK_HI) begin
            m = '0;
        end else begin
            unique case (a)
                6'h08:   m = 8'h13;  // reference select
                6'h09:   m = 8'h3F;  // positive channel
                6'h0B:   m = 8'h1F;  // precharge high
                6'h0D:   m = 8'h1F;  // acquisition high
                6'h0E:   m = 8'h1F;  // capacitance
                6'h19:   m = 8'h03;  // accumulator top
                default: m = 8'hFF;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/ctxrf_bank.sv
module ctxrf_bank
    import ctxrf_pkg::*;
#(
    parameter int ADDR_BITS = ADDR_W,
    parameter int DATA_BITS = DATA_W,
    parameter int NBYTES    = BANK_BYTES,
    parameter logic [ADDR_BITS-1:0] BASE = A_BANK_LO
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_BITS-1:0] addr,
    input  logic [DATA_BITS-1:0] wdata,
    input  logic                 cont_wr,
    input  logic                 cont_wdata,
    output logic [DATA_BITS-1:0] rdata,
    output logic                 cont_q
);

    localparam int IDX_W = $clog2(NBYTES);
    localparam logic [ADDR_BITS-1:0] NB_L = ADDR_BITS'(NBYTES);

    logic [DATA_BITS-1:0] mem [NBYTES];
    logic [ADDR_BITS-1:0] off;
    logic                 hit;
    logic [IDX_W-1:0]     idx;

    always_comb begin
        off = addr - BASE;
        hit = (off < NB_L);
        idx = off[IDX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] <= '0;
        end else if (wr_en && hit) begin
            mem[idx] <= wdata & bank_mask(addr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cont_q <= 1'b0;
        else if (cont_wr) cont_q <= cont_wdata;
    end

    always_comb rdata = hit ? mem[idx] : '0;

    AST_BANK_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((rdata & ~bank_mask(addr)) == '0)); // R9

endmodule

// File: rtl/ctxrf_global.sv
module ctxrf_global
    import ctxrf_pkg::*;
#(
    parameter int DATA_BITS = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 main_wr,
    input  logic                 clksel_wr,
    input  logic                 trig_wr,
    input  logic [DATA_BITS-1:0] wdata,
    output logic [DATA_BITS-1:0] main_q,
    output logic [DATA_BITS-1:0] clksel_q,
    output logic [DATA_BITS-1:0] trig_q
);

    localparam logic [DATA_BITS-1:0] MAIN_GLOBAL_MASK = ~(DATA_BITS'(1) << BIT_CONT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            main_q   <= '0;
            clksel_q <= '0;
            trig_q   <= '0;
        end else begin
            if (main_wr)   main_q   <= wdata & MAIN_GLOBAL_MASK;
            if (clksel_wr) clksel_q <= wdata;
            if (trig_wr)   trig_q   <= wdata;
        end
    end

    AST_CLKSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clksel_wr |=> (clksel_q == $past(clksel_q))); // R2

    AST_TRIG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_wr |=> (trig_q == $past(trig_q))); // R2

endmodule

// File: rtl/ctxrf_sel.sv
module ctxrf_sel
    import ctxrf_pkg::*;
#(
    parameter int CW        = CTX_W,
    parameter int DATA_BITS = DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_wr,
    input  logic                 wr_disp,
    input  logic [CW-1:0]        wr_field,
    input  logic                 seq_en,
    input  logic [CW-1:0]        seq_ctx,
    input  logic                 seq_stop,
    output logic [DATA_BITS-1:0] sel_rdata,
    output logic [CW-1:0]        bank_idx
);

    seq_state_e    state_q, state_d;
    logic          disp_q;
    logic [CW-1:0] soft_q;
    logic [CW-1:0] held_q;
    logic [CW-1:0] shown;
    logic          latch_now;

    // Next state.
    always_comb begin
        state_d   = state_q;
        latch_now = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (seq_en && seq_stop) begin
                    state_d   = ST_HALT;
                    latch_now = 1'b1;
                end else if (seq_en) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (!seq_en) begin
                    state_d = ST_IDLE;
                end else if (seq_stop) begin
                    state_d   = ST_HALT;
                    latch_now = 1'b1;
                end
            end
            ST_HALT: begin
                if (!seq_en) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and the latched context.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            if (latch_now) held_q <= seq_ctx;
        end
    end

    // Select register, written by software.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disp_q <= 1'b0;
            soft_q <= '0;
        end else if (sel_wr) begin
            disp_q <= wr_disp;
            if (!disp_q) soft_q <= wr_field;
        end
    end

    // Outputs.
    always_comb begin
        if (!seq_en)                shown = '0;
        else if (state_q == ST_HALT) shown = held_q;
        else                         shown = seq_ctx;
        bank_idx = disp_q ? shown : soft_q;
        sel_rdata           = '0;
        sel_rdata[BIT_DISP] = disp_q;
        sel_rdata[CW-1:0]   = disp_q ? shown : soft_q;
    end

    AST_FIELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && disp_q) |=> (soft_q == $past(soft_q))); // R5

    AST_DISP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_q && !seq_en) |-> (sel_rdata[CW-1:0] == '0)); // R6

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HALT && seq_en) |=> (held_q == $past(held_q) && state_q == ST_HALT)); // R7

endmodule

// File: rtl/ctxrf_top.sv
module ctxrf_top
    import ctxrf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CTX_W-1:0]  seq_ctx,
    input  logic              seq_stop
);

    logic [DATA_W-1:0] main_q, clksel_q, trig_q, sel_rdata;
    logic [CTX_W-1:0]  bank_idx;
    logic [DATA_W-1:0] bank_rd [NUM_CTX];
    logic              cont_rd [NUM_CTX];
    logic              main_wr, sel_wr, clksel_wr, trig_wr;

    always_comb begin
        main_wr   = bus_we && (bus_addr == A_MAIN);
        sel_wr    = bus_we && (bus_addr == A_SEL);
        clksel_wr = bus_we && (bus_addr == A_CLKSEL);
        trig_wr   = bus_we && (bus_addr == A_TRIG);
    end

    ctxrf_global #(.DATA_BITS(DATA_W)) u_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_wr   (main_wr),
        .clksel_wr (clksel_wr),
        .trig_wr   (trig_wr),
        .wdata     (bus_wdata),
        .main_q    (main_q),
        .clksel_q  (clksel_q),
        .trig_q    (trig_q)
    );

    ctxrf_sel #(.CW(CTX_W), .DATA_BITS(DATA_W)) u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_wr    (sel_wr),
        .wr_disp   (bus_wdata[BIT_DISP]),
        .wr_field  (bus_wdata[CTX_W-1:0]),
        .seq_en    (main_q[BIT_SEQEN]),
        .seq_ctx   (seq_ctx),
        .seq_stop  (seq_stop),
        .sel_rdata (sel_rdata),
        .bank_idx  (bank_idx)
    );

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_bank
        logic sel_this;
        always_comb sel_this = (bank_idx == CTX_W'(g));
        ctxrf_bank #(
            .ADDR_BITS (ADDR_W),
            .DATA_BITS (DATA_W),
            .NBYTES    (BANK_BYTES),
            .BASE      (A_BANK_LO)
        ) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bus_we && sel_this),
            .addr       (bus_addr),
            .wdata      (bus_wdata),
            .cont_wr    (main_wr && sel_this),
            .cont_wdata (bus_wdata[BIT_CONT]),
            .rdata      (bank_rd[g]),
            .cont_q     (cont_rd[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MAIN) begin
            bus_rdata           = main_q;
            bus_rdata[BIT_CONT] = cont_rd[bank_idx];
        end else if (bus_addr == A_SEL) begin
            bus_rdata = sel_rdata;
        end else if (bus_addr == A_CLKSEL) begin
            bus_rdata = clksel_q;
        end else if (bus_addr == A_TRIG) begin
            bus_rdata = trig_q;
        end else begin
            bus_rdata = bank_rd[bank_idx];
        end
    end

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr > A_BANK_HI) |-> (bus_rdata == '0)); // R10

endmodule

// File: tb/ctxrf_top_tb.sv
module ctxrf_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] seq_ctx = '0;
    logic       seq_stop = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctxrf_top u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .seq_ctx   (seq_ctx),
        .seq_stop  (seq_stop)
    );

    // Reference model.
    logic [7:0] mb [4][64];
    logic       m_cont [4];
    logic [7:0] m_main, m_clk, m_trig;
    logic       m_disp, m_halted;
    logic [1:0] m_soft, m_held;

    function automatic logic [7:0] imp_mask(input logic [5:0] a);
        if (a < 6'h04 || a > 6'h21) return 8'h00;
        case (a)
            6'h08:                      return 8'h13;
            6'h09:                      return 8'h3F;
            6'h0B, 6'h0D, 6'h0E:        return 8'h1F;
            6'h19:                      return 8'h03;
            default:                    return 8'hFF;
        endcase
    endfunction

    function automatic logic [1:0] m_shown(input logic [1:0] sc);
        if (!m_main[5]) return 2'd0;
        if (m_halted)   return m_held;
        return sc;
    endfunction

    function automatic logic [1:0] m_bank(input logic [1:0] sc);
        return m_disp ? m_shown(sc) : m_soft;
    endfunction

    function automatic logic [7:0] m_read(input logic [5:0] a, input logic [1:0] sc);
        logic [7:0] v;
        v = 8'h00;
        if (a == 6'h00) begin
            v = m_main;
            v[6] = m_cont[m_bank(sc)];
        end else if (a == 6'h01) begin
            v = {m_disp, 5'b0, m_disp ? m_shown(sc) : m_soft};
        end else if (a == 6'h02) v = m_clk;
        else if (a == 6'h03)    v = m_trig;
        else if (a <= 6'h21)    v = mb[m_bank(sc)][a];
        return v;
    endfunction

    function automatic string req_of(input logic [5:0] a);
        if (a == 6'h00) return "R3";
        if (a == 6'h01) return m_disp ? "R5" : "R4";
        if (a == 6'h02 || a == 6'h03) return "R2";
        if (a > 6'h21) return "R10";
        if (imp_mask(a) != 8'hFF) return "R9";
        return m_disp ? "R8" : "R1";
    endfunction

    task automatic m_reset();
        for (int b = 0; b < 4; b++) begin
            m_cont[b] = 1'b0;
            for (int a = 0; a < 64; a++) mb[b][a] = 8'h00;
        end
        m_main = 0; m_clk = 0; m_trig = 0;
        m_disp = 0; m_halted = 0; m_soft = 0; m_held = 0;
    endtask

    task automatic m_step(input logic [5:0] a, input logic we, input logic [7:0] wd,
                          input logic [1:0] sc, input logic stp);
        logic [1:0] b;
        b = m_bank(sc);
        if (!m_main[5]) m_halted = 1'b0;
        else if (!m_halted && stp) begin
            m_halted = 1'b1;
            m_held   = sc;
        end
        if (we) begin
            if (a == 6'h00) begin
                m_main = wd & 8'hBF;
                m_cont[b] = wd[6];
            end else if (a == 6'h01) begin
                if (!m_disp) m_soft = wd[1:0];
                m_disp = wd[7];
            end else if (a == 6'h02) m_clk = wd;
            else if (a == 6'h03) m_trig = wd;
            else if (a <= 6'h21) mb[b][a] = wd & imp_mask(a);
        end
    endtask

    // One bus cycle: drive after the falling edge, compare, advance the model.
    task automatic cyc(input string tag, input logic [5:0] a, input logic we,
                       input logic [7:0] wd, input logic [1:0] sc, input logic stp);
        logic [7:0] exp;
        string t;
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; seq_ctx = sc; seq_stop = stp;
        #1;
        exp = m_read(a, sc);
        t = (tag == "") ? req_of(a) : tag;
        n_checks++;
        if (bus_rdata !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%02h actual=%02h expected=%02h", t, a, bus_rdata, exp);
        end
        m_step(a, we, wd, sc, stp);
    endtask

    task automatic wr(input string tag, input logic [5:0] a, input logic [7:0] wd);
        cyc(tag, a, 1'b1, wd, 2'd0, 1'b0);
    endtask

    task automatic rd(input string tag, input logic [5:0] a, input logic [1:0] sc);
        cyc(tag, a, 1'b0, 8'h00, sc, 1'b0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: everything clear after reset.
        for (int a = 0; a < 64; a++) rd("R11", 6'(a), 2'd3);

        // R1 and R12: distinct value per bank, visible on the next cycle.
        for (int b = 0; b < 4; b++) begin
            wr("R4", 6'h01, 8'(b));
            wr("R12", 6'h13, 8'hA0 + 8'(b));
            rd("R12", 6'h13, 2'd0);
        end
        for (int b = 0; b < 4; b++) begin
            wr("R4", 6'h01, 8'(b));
            rd("R1", 6'h13, 2'd0);
        end

        // R2: global clock and trigger bytes written under context 2, read under 0.
        wr("R4", 6'h01, 8'h02);
        wr("R2", 6'h02, 8'h5A);
        wr("R2", 6'h03, 8'hC3);
        wr("R4", 6'h01, 8'h00);
        rd("R2", 6'h02, 2'd0);
        rd("R2", 6'h03, 2'd0);

        // R3: main control written under context 1; bit 6 stays private to it.
        wr("R4", 6'h01, 8'h01);
        wr("R3", 6'h00, 8'hDF);
        rd("R3", 6'h00, 2'd0);
        wr("R4", 6'h01, 8'h00);
        rd("R3", 6'h00, 2'd0);

        // R9: masked bytes.
        foreach (mb[0][a]) if (a >= 4 && a <= 8'h21 && imp_mask(6'(a)) != 8'hFF) begin
            wr("R9", 6'(a), 8'hFF);
            rd("R9", 6'(a), 2'd0);
        end

        // R10: unmapped write changes nothing.
        wr("R10", 6'h30, 8'hFF);
        rd("R10", 6'h30, 2'd0);
        rd("R10", 6'h3F, 2'd0);

        // Put known data into bank 3.
        wr("R4", 6'h01, 8'h03);
        wr("R1", 6'h20, 8'h77);
        wr("R4", 6'h01, 8'h00);

        // R6: display mode, enable off -> field reads 0.
        wr("R3", 6'h00, 8'h00);
        wr("R6", 6'h01, 8'h83);
        rd("R6", 6'h01, 2'd2);

        // R5: enable on, field follows seq_ctx, writes to the field ignored.
        wr("R3", 6'h00, 8'h20);
        rd("R5", 6'h01, 2'd2);
        cyc("R5", 6'h01, 1'b1, 8'h81, 2'd2, 1'b0);
        rd("R5", 6'h01, 2'd2);

        // R8: bank follows the sequencer context.
        rd("R8", 6'h20, 2'd3);
        rd("R8", 6'h20, 2'd1);

        // R7: stop latches 1, then seq_ctx moves.
        cyc("R7", 6'h01, 1'b0, 8'h00, 2'd1, 1'b1);
        rd("R7", 6'h01, 2'd3);
        cyc("R7", 6'h01, 1'b0, 8'h00, 2'd0, 1'b1);
        rd("R7", 6'h01, 2'd2);
        rd("R8", 6'h20, 2'd3);

        // R5: leaving display mode keeps the earlier software value.
        wr("R5", 6'h01, 8'h02);
        rd("R4", 6'h01, 2'd1);

        // Constrained random traffic.
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] a;
            logic       we;
            logic [7:0] wd;
            int         pick;
            pick = int'($urandom_range(0, 99));
            if (pick < 8)       a = 6'h00;
            else if (pick < 18) a = 6'h01;
            else if (pick < 24) a = 6'($urandom_range(2, 3));
            else if (pick < 30) a = 6'($urandom_range(34, 63));
            else                a = 6'($urandom_range(4, 33));
            we = ($urandom_range(0, 99) < 45);
            wd = 8'($urandom);
            if (a == 6'h00 && $urandom_range(0, 3) != 0) wd[5] = 1'b1;
            cyc("", a, we, wd, 2'($urandom), ($urandom_range(0, 99) < 4));
        end

        finish_run();
    end

endmodule